// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outgoing request path of a PCI Express controller. It takes a 64-bit request address and checks it against a set of programmed outbound windows. Each window has a base, a limit, a target address and a control word that sets the transaction type, the function number and whether an end-to-end CRC digest is asked for. When an enabled window contains the address, the block moves the address into the target space by keeping its offset from the window base. It also reports the window's attributes, so the packet builder downstream can form the request.

The window configuration arrives as flat per-window fields from a register bank outside this block. Each window has two control words (`ctl_a`, `ctl_b`), a 64-bit base, a 32-bit lower limit, a 32-bit upper limit and a 64-bit target. The lookup takes one cycle and is fully parallel. The result is registered and is held until the next request.

Top module: `ob_xlate`

## Requirements
- R1: A window covers the inclusive range from its base to its limit. When bit 13 of `ctl_a` is clear, the limit is formed from the window's upper base half and its 32-bit lower limit. An address outside that range, even by one, does not hit that window.
- R2: When bit 13 of `ctl_a` is set, the upper 32 bits of the limit are taken from the upper-limit field instead. This lets one window span a 4 GiB boundary.
- R3: A window takes part in matching only while bit 31 of its `ctl_b` word is set. Clearing that bit makes its addresses fall to the next matching window, or miss.
- R4: When several enabled windows contain the address, the window with the lowest index supplies the result.
- R5: On a hit, the output address is the target plus (address minus base), computed modulo 2^64.
- R6: On a hit, `out_type` is `ctl_a[4:0]`, `out_func` is `ctl_a[20 +: FUNC_W]` and `out_digest` is `ctl_a[8]`. The type codes are 0x0 for memory, 0x2 for I/O, 0x4 for configuration type 0 and 0x5 for configuration type 1.
- R7: A request that hits no window passes its address through unchanged, with `out_hit`, `out_type`, `out_func` and `out_digest` all zero.
- R8: The outputs are registered. `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. Without a request, every output except `out_valid` keeps its value.
- R9: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Untranslated request address |
| win_ctl_a | input | NUM_WIN x 32 | Per-window attribute word (type, digest, extended size, function) |
| win_ctl_b | input | NUM_WIN x 32 | Per-window enable word (bit 31) |
| win_base | input | NUM_WIN x 64 | Per-window base address |
| win_lim_lo | input | NUM_WIN x 32 | Per-window lower 32 bits of limit |
| win_lim_hi | input | NUM_WIN x 32 | Per-window upper 32 bits of limit, used with extended size |
| win_target | input | NUM_WIN x 64 | Per-window target address |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_hit | output | 1 | A window matched |
| out_addr | output | 64 | Translated or passed-through address |
| out_type | output | 5 | Transaction type code |
| out_func | output | FUNC_W | Function number |
| out_digest | output | 1 | Digest (ECRC) requested |

## Verification
Every result is due exactly one clock after the cycle in which `req_valid` was sampled high, with a single register between input and output. The bench drives each request on a falling edge and lowers the strobe on the next falling edge. It reads the outputs at that same falling edge, after the one rising edge that captured the request. It then checks that the strobe has dropped one cycle later while the other outputs hold. The checker states the same one-cycle relation with `|=>` properties.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;

    // attribute word (ctl_a) field positions
    localparam int TYPE_W      = 5;
    localparam int DIGEST_BIT  = 8;
    localparam int EXT_BIT     = 13;
    localparam int FUNC_LSB    = 20;
    // enable word (ctl_b) field position
    localparam int ENABLE_BIT  = 31;
    localparam int HALF_W      = 32;

    typedef enum logic [TYPE_W-1:0] {
        XT_MEM  = 5'h00,
        XT_IO   = 5'h02,
        XT_CFG0 = 5'h04,
        XT_CFG1 = 5'h05
    } xlate_type_e;

endpackage

// File: rtl/ob_win_match.sv
module ob_win_match #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                enable,
    input  logic                ext_size,
    input  logic [ADDR_W-1:0]   base,
    input  logic [ADDR_W/2-1:0] lim_lo,
    input  logic [ADDR_W/2-1:0] lim_hi,
    output logic                hit
);
    localparam int HW = ADDR_W / 2;

    logic [ADDR_W-1:0] limit;

    always_comb begin
        // without the extended-size bit, the limit shares the base's upper half
        limit = {(ext_size ? lim_hi : base[ADDR_W-1:HW]), lim_lo};
        hit   = enable && (addr >= base) && (addr <= limit);
    end
endmodule

// File: rtl/ob_prio_pick.sv
module ob_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]                 req,
    output logic                         any,
    output logic [(N>1?$clog2(N):1)-1:0] idx
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    always_comb begin
        any = |req;
        idx = '0;
        // scan downward so the lowest set index is the last assignment
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ob_xlate.sv
module ob_xlate
    import ob_xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 64,
    parameter int FUNC_W  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [NUM_WIN-1:0][31:0]          win_ctl_a,
    input  logic [NUM_WIN-1:0][31:0]          win_ctl_b,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]    win_base,
    input  logic [NUM_WIN-1:0][ADDR_W/2-1:0]  win_lim_lo,
    input  logic [NUM_WIN-1:0][ADDR_W/2-1:0]  win_lim_hi,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]    win_target,
    output logic                              out_valid,
    output logic                              out_hit,
    output logic [ADDR_W-1:0]                 out_addr,
    output logic [TYPE_W-1:0]                 out_type,
    output logic [FUNC_W-1:0]                 out_func,
    output logic                              out_digest
);
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [TYPE_W-1:0] typ;
        logic [FUNC_W-1:0] func;
        logic              digest;
    } res_t;

    res_t res_d, res_q;

    logic [NUM_WIN-1:0] win_hit;
    logic               any_hit;
    logic [IDX_W-1:0]   sel;
    logic [31:0]        sel_ctl;
    logic               unused_cfg_bits;

    assign unused_cfg_bits = ^{win_ctl_a, win_ctl_b};

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        ob_win_match #(.ADDR_W(ADDR_W)) u_match (
            .addr     (req_addr),
            .enable   (win_ctl_b[w][ENABLE_BIT]),
            .ext_size (win_ctl_a[w][EXT_BIT]),
            .base     (win_base[w]),
            .lim_lo   (win_lim_lo[w]),
            .lim_hi   (win_lim_hi[w]),
            .hit      (win_hit[w])
        );
    end

    ob_prio_pick #(.N(NUM_WIN)) u_pick (
        .req (win_hit),
        .any (any_hit),
        .idx (sel)
    );

    always_comb begin
        sel_ctl     = win_ctl_a[sel];
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (req_valid) begin
            res_d.valid = 1'b1;
            if (any_hit) begin
                res_d.hit    = 1'b1;
                res_d.addr   = win_target[sel] + (req_addr - win_base[sel]);
                res_d.typ    = sel_ctl[TYPE_W-1:0];
                res_d.func   = sel_ctl[FUNC_LSB +: FUNC_W];
                res_d.digest = sel_ctl[DIGEST_BIT];
            end else begin
                res_d.hit    = 1'b0;
                res_d.addr   = req_addr;
                res_d.typ    = '0;
                res_d.func   = '0;
                res_d.digest = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid  = res_q.valid;
    assign out_hit    = res_q.hit;
    assign out_addr   = res_q.addr;
    assign out_type   = res_q.typ;
    assign out_func   = res_q.func;
    assign out_digest = res_q.digest;
endmodule

// File: rtl/ob_xlate_chk.sv
module ob_xlate_chk
    import ob_xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 64,
    parameter int FUNC_W  = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic [ADDR_W-1:0]              req_addr,
    input logic [NUM_WIN-1:0][31:0]       win_ctl_a,
    input logic [NUM_WIN-1:0][31:0]       win_ctl_b,
    input logic [NUM_WIN-1:0][ADDR_W-1:0] win_base,
    input logic [NUM_WIN-1:0][ADDR_W-1:0] win_target,
    input logic                           out_valid,
    input logic                           out_hit,
    input logic [ADDR_W-1:0]              out_addr,
    input logic [TYPE_W-1:0]              out_type,
    input logic [FUNC_W-1:0]              out_func,
    input logic                           out_digest
);
    logic [NUM_WIN-1:0] en_vec;
    logic               unused_chk_bits;

    always_comb begin
        for (int i = 0; i < NUM_WIN; i++) en_vec[i] = win_ctl_b[i][ENABLE_BIT];
    end
    assign unused_chk_bits = ^{win_ctl_a, win_ctl_b};

    // R8: the result strobe follows the request strobe by one cycle
    p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_hit)));

    // R3, R7: with every window disabled the address passes unchanged
    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (en_vec == '0)) |=> (!out_hit && out_addr == $past(req_addr)));

    // R7: a miss carries no attributes
    p_miss_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (!out_digest && out_type == '0 && out_func == '0));

    // R1, R4, R5: an address equal to window 0's base hits and lands on its target
    p_base_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && en_vec[0] && req_addr == win_base[0])
        |=> (out_hit && out_addr == $past(win_target[0])
             && out_func == $past(win_ctl_a[0][FUNC_LSB +: FUNC_W])));
endmodule

bind ob_xlate ob_xlate_chk #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W),
    .FUNC_W  (FUNC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .win_ctl_a  (win_ctl_a),
    .win_ctl_b  (win_ctl_b),
    .win_base   (win_base),
    .win_target (win_target),
    .out_valid  (out_valid),
    .out_hit    (out_hit),
    .out_addr   (out_addr),
    .out_type   (out_type),
    .out_func   (out_func),
    .out_digest (out_digest)
);

// File: tb/ob_xlate_bench.sv
`timescale 1ns/1ps
module ob_xlate_bench;
    localparam int NW = 4;
    localparam int AW = 64;
    localparam int FW = 3;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      req_valid = 1'b0;
    logic [AW-1:0]             req_addr = '0;
    logic [NW-1:0][31:0]       win_ctl_a = '0;
    logic [NW-1:0][31:0]       win_ctl_b = '0;
    logic [NW-1:0][AW-1:0]     win_base = '0;
    logic [NW-1:0][AW/2-1:0]   win_lim_lo = '0;
    logic [NW-1:0][AW/2-1:0]   win_lim_hi = '0;
    logic [NW-1:0][AW-1:0]     win_target = '0;
    logic                      out_valid, out_hit, out_digest;
    logic [AW-1:0]             out_addr;
    logic [4:0]                out_type;
    logic [FW-1:0]             out_func;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ob_xlate #(.NUM_WIN(NW), .ADDR_W(AW), .FUNC_W(FW)) u_ob_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .win_ctl_a(win_ctl_a), .win_ctl_b(win_ctl_b), .win_base(win_base),
        .win_lim_lo(win_lim_lo), .win_lim_hi(win_lim_hi), .win_target(win_target),
        .out_valid(out_valid), .out_hit(out_hit), .out_addr(out_addr),
        .out_type(out_type), .out_func(out_func), .out_digest(out_digest)
    );

    typedef struct packed {
        logic [63:0] addr;
        logic        hit;
        logic [63:0] xaddr;
        logic [4:0]  typ;
        logic [2:0]  fn;
        logic        dig;
    } vec_t;

    // windows: 0 = mem 0x1000_0000..0x1000_FFFF, 1 = io extended 0x1_F000_0000..0x2_0000_FFFF,
    // 2 = cfg0 0x1000_8000..0x1001_0FFF (overlaps 0), 3 = cfg1 0x2000_0000..0x2000_0FFF (disabled)
    localparam vec_t VEC [0:10] = '{
        '{64'h0000_0000_1000_0000, 1'b1, 64'h0000_00AB_0000_0000, 5'h0, 3'd1, 1'b0}, // R1 base edge
        '{64'h0000_0000_1000_FFFF, 1'b1, 64'h0000_00AB_0000_FFFF, 5'h0, 3'd1, 1'b0}, // R1 limit edge
        '{64'h0000_0000_1001_0000, 1'b1, 64'h0000_0000_5000_8000, 5'h4, 3'd3, 1'b0}, // R6 cfg0
        '{64'h0000_0000_0FFF_FFFF, 1'b0, 64'h0000_0000_0FFF_FFFF, 5'h0, 3'd0, 1'b0}, // R7 below base
        '{64'h0000_0000_1000_8000, 1'b1, 64'h0000_00AB_0000_8000, 5'h0, 3'd1, 1'b0}, // R4 overlap
        '{64'h0000_0001_F000_0000, 1'b1, 64'h0000_0000_8000_0000, 5'h2, 3'd2, 1'b1}, // R2 io base
        '{64'h0000_0002_0000_FFFF, 1'b1, 64'h0000_0000_9000_FFFF, 5'h2, 3'd2, 1'b1}, // R2 io limit
        '{64'h0000_0002_0001_0000, 1'b0, 64'h0000_0002_0001_0000, 5'h0, 3'd0, 1'b0}, // R2 past limit
        '{64'h0000_0000_2000_0010, 1'b0, 64'h0000_0000_2000_0010, 5'h0, 3'd0, 1'b0}, // R3 disabled
        '{64'h0000_0001_1000_0000, 1'b0, 64'h0000_0001_1000_0000, 5'h0, 3'd0, 1'b0}, // R1 upper half
        '{64'h0000_0000_1001_1000, 1'b0, 64'h0000_0000_1001_1000, 5'h0, 3'd0, 1'b0}  // R1 past limit
    };

    function automatic logic [31:0] mk_ctl(input logic [4:0] t, input logic [2:0] f,
                                           input logic d, input logic ext);
        return (32'(f) << 20) | (32'(ext) << 13) | (32'(d) << 8) | 32'(t);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive on a falling edge, sample at the next falling edge (one register)
    task automatic issue(input logic [63:0] a);
        req_addr  = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic h, input logic [63:0] xa,
                              input logic [4:0] t, input logic [2:0] f, input logic d);
        check("R8", "out_valid", 64'(out_valid), 64'd1);
        check(req, "out_hit", 64'(out_hit), 64'(h));
        check(h ? "R5" : "R7", "out_addr", out_addr, xa);
        check(h ? "R6" : "R7", "out_type", 64'(out_type), 64'(t));
        check(h ? "R6" : "R7", "out_func", 64'(out_func), 64'(f));
        check(h ? "R6" : "R7", "out_digest", 64'(out_digest), 64'(d));
    endtask

    initial begin
        win_ctl_a[0] = mk_ctl(5'h0, 3'd1, 1'b0, 1'b0);
        win_ctl_b[0] = 32'h8000_0000;
        win_base[0]  = 64'h0000_0000_1000_0000;
        win_lim_lo[0] = 32'h1000_FFFF;
        win_lim_hi[0] = 32'h0000_0007;  // ignored: extended size is off
        win_target[0] = 64'h0000_00AB_0000_0000;

        win_ctl_a[1] = mk_ctl(5'h2, 3'd2, 1'b1, 1'b1);
        win_ctl_b[1] = 32'h8000_0000;
        win_base[1]  = 64'h0000_0001_F000_0000;
        win_lim_lo[1] = 32'h0000_FFFF;
        win_lim_hi[1] = 32'h0000_0002;
        win_target[1] = 64'h0000_0000_8000_0000;

        win_ctl_a[2] = mk_ctl(5'h4, 3'd3, 1'b0, 1'b0);
        win_ctl_b[2] = 32'h8000_0000;
        win_base[2]  = 64'h0000_0000_1000_8000;
        win_lim_lo[2] = 32'h1001_0FFF;
        win_target[2] = 64'h0000_0000_5000_0000;

        win_ctl_a[3] = mk_ctl(5'h5, 3'd7, 1'b1, 1'b0);
        win_ctl_b[3] = 32'h0000_0000;
        win_base[3]  = 64'h0000_0000_2000_0000;
        win_lim_lo[3] = 32'h2000_0FFF;
        win_target[3] = 64'h0000_0000_C000_0000;

        // R9: reset state, with a request pending during reset
        req_valid = 1'b1;
        req_addr  = 64'h0000_0000_1000_0000;
        repeat (3) @(negedge clk);
        check("R9", "out_valid", 64'(out_valid), 64'd0);
        check("R9", "out_hit", 64'(out_hit), 64'd0);
        check("R9", "out_addr", out_addr, 64'd0);
        check("R9", "out_digest", 64'(out_digest), 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i <= 10; i++) begin
            issue(VEC[i].addr);
            expect_res(VEC[i].hit ? "R1/R2/R4 hit" : "R1/R3 miss", VEC[i].hit, VEC[i].xaddr,
                       VEC[i].typ, VEC[i].fn, VEC[i].dig);
        end

        // R8: after a hit, idle cycles drop the strobe and hold the result
        issue(64'h0000_0001_F000_0010);
        req_addr = 64'h0000_0000_0000_1234;
        @(negedge clk);
        check("R8", "out_valid idle", 64'(out_valid), 64'd0);
        check("R8", "out_addr held", out_addr, 64'h0000_0000_8000_0010);
        check("R8", "out_hit held", 64'(out_hit), 64'd1);
        check("R8", "out_digest held", 64'(out_digest), 64'd1);

        // R3: disabling window 0 lets the overlap fall to window 2
        win_ctl_b[0] = 32'h7FFF_FFFF;
        issue(64'h0000_0000_1000_8000);
        expect_res("R3", 1'b1, 64'h0000_0000_5000_0000, 5'h4, 3'd3, 1'b0);
        issue(64'h0000_0000_1000_0000);
        expect_res("R3", 1'b0, 64'h0000_0000_1000_0000, 5'h0, 3'd0, 1'b0);
        win_ctl_b[0] = 32'h8000_0000;
        issue(64'h0000_0000_1000_8000);
        expect_res("R4", 1'b1, 64'h0000_00AB_0000_8000, 5'h0, 3'd1, 1'b0);

        // R5: translation wraps modulo 2^64; R6: config type 1 with digest
        win_ctl_b[3]  = 32'h8000_0000;
        win_target[3] = 64'hFFFF_FFFF_FFFF_F800;
        issue(64'h0000_0000_2000_0FFF);
        expect_res("R5", 1'b1, 64'h0000_0000_0000_07FF, 5'h5, 3'd7, 1'b1);
        issue(64'h0000_0000_2000_1000);
        expect_res("R1", 1'b0, 64'h0000_0000_2000_1000, 5'h0, 3'd0, 1'b0);

        // R2: the same window without extended size stops at its upper base half
        win_ctl_a[1] = mk_ctl(5'h2, 3'd2, 1'b1, 1'b0);
        issue(64'h0000_0002_0000_0000);
        expect_res("R2", 1'b0, 64'h0000_0002_0000_0000, 5'h0, 3'd0, 1'b0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule